// File: doc/BRIEF.md
# Shared-Adder Integer ALU with Bit-Serial Divider

This block is a parameterised integer arithmetic and logic unit, 16 bits wide by default. A caller raises `start` for one cycle with a 3-bit opcode and two operands. The unit produces one of eight results: sum, difference, full-width product, quotient with remainder, or one of four bitwise operations.

Every add-type operation goes through one carry-select adder. Each section of that adder computes two ripple sums, one for an incoming carry of 0 and one for 1, and the real carry chooses between them. Subtraction feeds the inverted subtrahend with a carry-in of 1 into the same adder. Multiplication sums partial products column by column and passes each column's carry to the next. Division is a restoring state machine that produces one quotient bit per clock. For each trial subtraction it takes the shared adder, so the divider has no arithmetic of its own.

Every result is registered. A non-divide result is ready on the cycle after the start edge. A divide result is ready after WIDTH clock edges of iteration.

Top module: `shared_alu`

## Requirements
- R1: Opcode 000 (add) gives result[WIDTH-1:0] = A+B modulo 2^WIDTH and carryFlag = the carry out of bit WIDTH-1. The upper half of result is 0.
- R2: Opcode 001 (subtract) gives result[WIDTH-1:0] = A-B modulo 2^WIDTH and carryFlag = 1 exactly when A < B (borrow). The upper half of result is 0.
- R3: Opcode 010 (multiply) gives the full unsigned 2*WIDTH-bit product A*B on result, with carryFlag 0.
- R4: The bitwise opcodes give their result in the low half, with the upper half 0 and carryFlag 0:
  - 100 gives A AND B.
  - 101 gives A OR B.
  - 110 gives NOR of A and B.
  - 111 gives NOT A.
- R5: zeroFlag is 1 exactly when the whole result of the last completed operation is 0.
- R6: For a non-divide opcode accepted at a clock edge, done is 1 and the new outputs are present in the cycle after that edge, and busy stays 0.
- R7: Opcode 011 (divide) has the following timing and results:
  - busy is 1 for exactly WIDTH cycles after the start edge, and done is 0 during those cycles.
  - done rises in the cycle after that, with result[WIDTH-1:0] = A/B (unsigned), remainder = A mod B and an upper half of 0.
  - Operands are captured at the start edge.
- R8: Dividing by B = 0 gives a quotient of all ones and remainder = A, and sets divZeroFlag. Every other operation clears divZeroFlag.
- R9: start is ignored while busy is 1. The running divide finishes on its own schedule with its own result.
- R10: After reset, result, remainder, busy, done and all flags are 0.
- R11: done is high for a single cycle per operation, and result holds its value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests an operation; sampled when not busy |
| opcode | input | 3 | Operation select (see requirements) |
| opA | input | WIDTH | Operand A (dividend, NOT source) |
| opB | input | WIDTH | Operand B (divisor) |
| result | output | 2*WIDTH | Result; product uses all bits, other operations the low half |
| remainder | output | WIDTH | Divide remainder, 0 for other operations |
| busy | output | 1 | Divider is iterating |
| done | output | 1 | One-cycle completion pulse |
| carryFlag | output | 1 | Carry for add, borrow for subtract |
| zeroFlag | output | 1 | Result is zero |
| divZeroFlag | output | 1 | Last divide had a zero divisor |

## Verification
A non-divide result and its done pulse are due one clock edge after the edge that samples start. The bench drives start at a falling edge and checks outputs at the next falling edge.

A divide keeps busy high at each of the next WIDTH falling edges and shows done with its quotient and remainder at the falling edge after those. The bench walks through that window one falling edge at a time and checks busy at each step.

During some divides the bench raises start with a different opcode partway through and changes the operands. It then confirms that the quotient, remainder and timing are unaffected. One more falling edge after every operation confirms that done has dropped and result is held.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_DIV = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_NOR = 3'b110,
    OP_NOT = 3'b111
  } alu_op_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadComb;  // capture a single-cycle result
    logic divInit;   // load dividend and divisor
    logic divStep;   // one restoring iteration
    logic divLast;   // final iteration, publish quotient
  } alu_strobe_t;

endpackage

// File: rtl/alu_csel_adder.sv
module alu_csel_adder #(
  parameter int WIDTH = 16,
  parameter int SECT  = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSEC = WIDTH / SECT;

  function automatic logic [SECT:0] ripple(input logic [SECT-1:0] x,
                                           input logic [SECT-1:0] y,
                                           input logic c);
    logic [SECT:0] r;
    logic cc;
    cc = c;
    for (int i = 0; i < SECT; i++) begin
      r[i] = x[i] ^ y[i] ^ cc;
      cc   = (x[i] & y[i]) | (cc & (x[i] ^ y[i]));
    end
    r[SECT] = cc;
    return r;
  endfunction

  logic [NSEC:0] chain;
  assign chain[0] = cin;

  // Each section precomputes both carry-in cases; the real carry selects.
  for (genvar g = 0; g < NSEC; g++) begin : g_sect
    logic [SECT:0] sumC0, sumC1;
    assign sumC0 = ripple(a[g*SECT +: SECT], b[g*SECT +: SECT], 1'b0);
    assign sumC1 = ripple(a[g*SECT +: SECT], b[g*SECT +: SECT], 1'b1);
    assign sum[g*SECT +: SECT] = chain[g] ? sumC1[SECT-1:0] : sumC0[SECT-1:0];
    assign chain[g+1]          = chain[g] ? sumC1[SECT]     : sumC0[SECT];
  end

  assign cout = chain[NSEC];
endmodule

// File: rtl/alu_colmul.sv
module alu_colmul #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int CW = $clog2(2*WIDTH) + 2;

  logic [CW-1:0] colSum [2*WIDTH];

  // Vertical-and-crosswise: column k collects every a[i]&b[j] with i+j==k.
  always_comb begin
    logic [CW-1:0] acc;
    logic [CW-1:0] carry;
    for (int k = 0; k < 2*WIDTH; k++) colSum[k] = '0;
    for (int i = 0; i < WIDTH; i++)
      for (int j = 0; j < WIDTH; j++)
        colSum[i+j] = colSum[i+j] + CW'(a[i] & b[j]);
    carry = '0;
    for (int k = 0; k < 2*WIDTH; k++) begin
      acc     = colSum[k] + carry;
      prod[k] = acc[0];
      carry   = acc >> 1;
    end
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  opcode,
  output alu_strobe_t strobe,
  output logic        busy,
  output logic        done
);
  localparam int CW = $clog2(WIDTH);

  typedef enum logic {ST_IDLE, ST_DIVIDE} ctrl_state_e;

  ctrl_state_e   state;
  logic [CW-1:0] stepCnt;
  logic          accepted;

  assign accepted        = start && (state == ST_IDLE);
  assign strobe.loadComb = accepted && (alu_op_e'(opcode) != OP_DIV);
  assign strobe.divInit  = accepted && (alu_op_e'(opcode) == OP_DIV);
  assign strobe.divStep  = (state == ST_DIVIDE);
  assign strobe.divLast  = strobe.divStep && (stepCnt == CW'(WIDTH-1));
  assign busy            = (state == ST_DIVIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.loadComb | strobe.divLast;
      if (strobe.divInit) begin
        state   <= ST_DIVIDE;
        stepCnt <= '0;
      end else if (strobe.divLast) begin
        state <= ST_IDLE;
      end else if (strobe.divStep) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SECT  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  alu_strobe_t        strobe,
  input  logic [2:0]         opcode,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] result,
  output logic [WIDTH-1:0]   remainder,
  output logic               carryFlag,
  output logic               zeroFlag,
  output logic               divZeroFlag
);
  alu_op_e op;
  assign op = alu_op_e'(opcode);

  logic [WIDTH-1:0] divReg, remReg, quoReg;
  logic [WIDTH-1:0] shifted, addA, addB, addSum, remNext, quoNext;
  logic             addCin, addCout, accept;
  logic [2*WIDTH-1:0] product, combRes;
  logic             combCarry;

  // Shared adder: the divider owns it while iterating.
  assign shifted = {remReg[WIDTH-2:0], quoReg[WIDTH-1]};
  assign addA    = strobe.divStep ? shifted : opA;
  assign addB    = strobe.divStep ? ~divReg : ((op == OP_SUB) ? ~opB : opB);
  assign addCin  = strobe.divStep | (op == OP_SUB);

  alu_csel_adder #(.WIDTH(WIDTH), .SECT(SECT)) u_adder (
    .a(addA), .b(addB), .cin(addCin), .sum(addSum), .cout(addCout)
  );

  alu_colmul #(.WIDTH(WIDTH)) u_mul (.a(opA), .b(opB), .prod(product));

  // A bit shifted out of the partial remainder means it already exceeds the divisor.
  assign accept  = addCout | remReg[WIDTH-1];
  assign remNext = accept ? addSum : shifted;
  assign quoNext = {quoReg[WIDTH-2:0], accept};

  always_comb begin
    combRes   = '0;
    combCarry = 1'b0;
    unique case (op)
      OP_ADD: begin combRes[WIDTH-1:0] = addSum; combCarry = addCout;  end
      OP_SUB: begin combRes[WIDTH-1:0] = addSum; combCarry = ~addCout; end
      OP_MUL: combRes = product;
      OP_AND: combRes[WIDTH-1:0] = opA & opB;
      OP_OR:  combRes[WIDTH-1:0] = opA | opB;
      OP_NOR: combRes[WIDTH-1:0] = ~(opA | opB);
      OP_NOT: combRes[WIDTH-1:0] = ~opA;
      OP_DIV: combRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      remainder   <= '0;
      carryFlag   <= 1'b0;
      zeroFlag    <= 1'b0;
      divZeroFlag <= 1'b0;
      divReg      <= '0;
      remReg      <= '0;
      quoReg      <= '0;
    end else if (strobe.loadComb) begin
      result      <= combRes;
      remainder   <= '0;
      carryFlag   <= combCarry;
      zeroFlag    <= (combRes == '0);
      divZeroFlag <= 1'b0;
    end else if (strobe.divInit) begin
      divReg <= opB;
      remReg <= '0;
      quoReg <= opA;
    end else if (strobe.divStep) begin
      remReg <= remNext;
      quoReg <= quoNext;
      if (strobe.divLast) begin
        result      <= {{WIDTH{1'b0}}, quoNext};
        remainder   <= remNext;
        carryFlag   <= 1'b0;
        zeroFlag    <= (quoNext == '0);
        divZeroFlag <= (divReg == '0);
      end
    end
  end
endmodule

// File: rtl/shared_alu.sv
module shared_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SECT  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [2:0]         opcode,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] result,
  output logic [WIDTH-1:0]   remainder,
  output logic               busy,
  output logic               done,
  output logic               carryFlag,
  output logic               zeroFlag,
  output logic               divZeroFlag
);
  alu_strobe_t strobe;

  alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .strobe(strobe), .busy(busy), .done(done)
  );

  alu_dpath #(.WIDTH(WIDTH), .SECT(SECT)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .opcode(opcode),
    .opA(opA), .opB(opB), .result(result), .remainder(remainder),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .divZeroFlag(divZeroFlag)
  );
endmodule

// File: rtl/shared_alu_chk.sv
module shared_alu_chk #(
  parameter int WIDTH = 16,
  parameter int SECT  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [2:0]         opcode,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [2*WIDTH-1:0] result,
  input logic [WIDTH-1:0]   remainder,
  input logic               busy,
  input logic               done,
  input logic               carryFlag,
  input logic               zeroFlag,
  input logic               divZeroFlag
);
  localparam int RW = $clog2(WIDTH + 2) + 1;

  logic [RW-1:0] busyRun;
  always_ff @(posedge clk) begin
    if (rst)       busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  AST_COMB_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && opcode != 3'b011) |=> (done && !busy)); // R6
  AST_DIV_ENTERS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && opcode == 3'b011) |=> (busy && !done)); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R7
  AST_DIV_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && busyRun == RW'(WIDTH))); // R9
  AST_DIVZERO_QUOT: assert property (@(posedge clk) disable iff (rst)
    (done && divZeroFlag) |-> (result[WIDTH-1:0] == '1)); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R11
endmodule

bind shared_alu shared_alu_chk #(.WIDTH(WIDTH), .SECT(SECT)) u_chk (.*);

// File: tb/test_shared_alu.sv
module test_shared_alu;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst, start;
  logic [2:0]     opcode;
  logic [W-1:0]   opA, opB;
  logic [2*W-1:0] result;
  logic [W-1:0]   remainder;
  logic           busy, done, carryFlag, zeroFlag, divZeroFlag;

  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  shared_alu #(.WIDTH(W)) i_shared_alu (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .opA(opA), .opB(opB),
    .result(result), .remainder(remainder), .busy(busy), .done(done),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .divZeroFlag(divZeroFlag)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  function automatic void model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [2*W-1:0] r, output logic [W-1:0] rm,
                                output logic c, output logic dz);
    logic [W:0] wide;
    r = '0; rm = '0; c = 1'b0; dz = 1'b0;
    case (op)
      3'd0: begin wide = {1'b0, a} + {1'b0, b}; r[W-1:0] = wide[W-1:0]; c = wide[W]; end
      3'd1: begin r[W-1:0] = a - b; c = (a < b); end
      3'd2: r = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      3'd3: if (b == 0) begin r[W-1:0] = '1; rm = a; dz = 1'b1; end
            else begin r[W-1:0] = a / b; rm = a % b; end
      3'd4: r[W-1:0] = a & b;
      3'd5: r[W-1:0] = a | b;
      3'd6: r[W-1:0] = ~(a | b);
      default: r[W-1:0] = ~a;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1 add";
      3'd1: return "R2 sub";
      3'd2: return "R3 mul";
      3'd3: return "R7 div";
      default: return "R4 logic";
    endcase
  endfunction

  task automatic doOp(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit poke);
    logic [2*W-1:0] eR;
    logic [W-1:0]   eRm;
    logic           eC, eDz;
    string          t;
    model(op, a, b, eR, eRm, eC, eDz);
    t = tagOf(op);
    if (op == 3'd3 && b == 0) t = "R8 divzero";
    @(negedge clk);
    start = 1'b1; opcode = op; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    if (op != 3'd3) begin
      chk("R6 done", done, 1);
      chk("R6 busy", busy, 0);
    end else begin
      chk("R7 busy", busy, 1);
      chk("R7 done low", done, 0);
      opA = ~a; opB = b ^ 16'h5a5a;   // operands must be captured
      for (int k = 1; k < W; k++) begin
        if (poke && k == 3) begin start = 1'b1; opcode = 3'd0; end
        else start = 1'b0;
        @(negedge clk);
        chk(poke ? "R9 busy" : "R7 busy", busy, 1);
      end
      start = 1'b0;
      @(negedge clk);
      chk(poke ? "R9 done" : "R7 done", done, 1);
      chk("R7 busy end", busy, 0);
    end
    chk({t, " result"}, result, eR);
    chk({t, " remainder"}, remainder, eRm);
    chk({t, " carry"}, carryFlag, eC);
    chk("R8 divzero flag", divZeroFlag, eDz);
    chk("R5 zero", zeroFlag, (eR == 0));
    @(negedge clk);
    chk("R11 done pulse", done, 0);
    chk("R11 result hold", result, eR);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; opcode = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 result", result, 0);
    chk("R10 remainder", remainder, 0);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 flags", {carryFlag, zeroFlag, divZeroFlag}, 0);

    doOp(3'd0, 16'hffff, 16'h0001, 0);   // R1 carry out, zero result
    doOp(3'd0, 16'h1234, 16'h4321, 0);   // R1
    doOp(3'd1, 16'h0000, 16'h0001, 0);   // R2 borrow
    doOp(3'd1, 16'h7777, 16'h7777, 0);   // R2 zero
    doOp(3'd2, 16'hffff, 16'hffff, 0);   // R3 max product
    doOp(3'd2, 16'h0000, 16'hbeef, 0);   // R3 zero
    doOp(3'd4, 16'hf0f0, 16'h0ff0, 0);   // R4
    doOp(3'd5, 16'hf000, 16'h000f, 0);   // R4
    doOp(3'd6, 16'h0000, 16'h0000, 0);   // R4 NOR all ones
    doOp(3'd7, 16'hffff, 16'h1234, 0);   // R4 NOT to zero
    doOp(3'd3, 16'hbeef, 16'h0000, 0);   // R8
    doOp(3'd3, 16'h0005, 16'h0009, 0);   // R7 A<B
    doOp(3'd3, 16'hffff, 16'h0001, 0);   // R7 divide by one
    doOp(3'd3, 16'hffff, 16'hffff, 1);   // R9 interference
    doOp(3'd3, 16'hc350, 16'h0007, 1);   // R9

    for (int n = 0; n < 300; n++) begin
      logic [2:0]   op;
      logic [W-1:0] a, b;
      op = 3'($urandom_range(0, 7));
      a  = W'($urandom);
      b  = W'($urandom);
      if (n % 17 == 0) b = '0;
      doOp(op, a, b, (n % 5 == 0));
    end
    finishRun();
  end
endmodule